// File: doc/BRIEF.md
# Serial Loader Entry Sequencer with 8E1 Link

This block sits on the host side of a link to a target microcontroller. It brings the target into its on-chip serial loader. It drives the target's reset line and its test-clock line through a fixed handshake waveform. It then transmits a synchronization byte and waits for the target's one-byte reply. After that the same port serves as a byte-level asynchronous serial link: 8 data bits, even parity, one stop bit, at 9600 baud at the default divider.

A second helper streams the 32-byte unlock password over the same transmitter. The password is the 16-word interrupt-vector image of the target. The host supplies each word on request through an index/word pair. A select input can replace the words with the all-ones image of an erased device.

Requests reach the single transmitter in a fixed priority order. The entry sequence goes first, then the password stream, then ordinary user bytes. The receiver runs continuously. It oversamples each bit at 16 ticks per bit and samples at mid-bit.

Top module: `bsl_entry_link`

## Requirements
- R1: After reset, `tgt_reset_n` is 1, `tgt_testclk` is 0, `txd` is 1, and `busy`, `entry_timeout`, `pw_active` and `rx_err` are all 0.
- R2: After an accepted `entry_start`, the pin pair {`tgt_reset_n`,`tgt_testclk`} steps through 00, 01, 00, 01, 11 and then 10. The reset line therefore rises only while the test clock is high, and the final fall of the test clock ends the waveform.
- R3: Each of the five phases (00, 01, 00, 01, 11) lasts exactly max(`phase_len`, BIT_CLKS) clocks, where BIT_CLKS = 16·TICK_DIV.
- R4: When the waveform ends, the block transmits the SYNC_BYTE parameter (default 0x80) as one serial frame.
- R5: `busy` is high from the clock after an accepted `entry_start` until the acknowledge arrives or the timeout expires. An `entry_start` while `busy` is high has no effect on the pins.
- R6: The first byte received after the sync byte is sent appears on `ack_data`, with `ack_valid` high for one clock, and ends the entry.
- R7: If no byte arrives within TIMEOUT_CLKS clocks of the sync byte being accepted by the transmitter, `busy` falls on exactly that clock and `entry_timeout` goes to 1. `entry_timeout` stays at 1 until the next accepted start.
- R8: Every transmitted frame consists of a 0 start bit, then 8 data bits LSB first, then a parity bit equal to the XOR of the data bits (even parity), then a 1 stop bit. Each bit lasts BIT_CLKS clocks.
- R9: A correct frame on `rxd` produces one `rx_valid` pulse with the data byte on `rx_data`.
- R10: `rx_err` is set by a received frame whose parity bit differs from the XOR of its data bits or whose stop bit is 0. The byte is still delivered, and the flag stays set until reset.
- R11: `pw_go` starts a 32-byte stream. Words are taken at `pw_index` 0 to 15 in ascending order, and each word is sent low byte first.
- R12: With `pw_erased` = 1, every password byte is 0xFF whatever `pw_word` holds.
- R13: `tx_ready` is 0 while `busy` or `pw_active` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| entry_start | input | 1 | Start the loader-entry sequence |
| phase_len | input | PHW | Requested clocks per waveform phase |
| tgt_reset_n | output | 1 | Target reset line, low = reset |
| tgt_testclk | output | 1 | Target test-clock line |
| txd | output | 1 | Serial data to target |
| rxd | input | 1 | Serial data from target |
| busy | output | 1 | Entry sequence in progress |
| ack_valid | output | 1 | One-clock strobe: sync reply received |
| ack_data | output | 8 | Sync reply byte |
| entry_timeout | output | 1 | No sync reply in time |
| pw_go | input | 1 | Start password stream |
| pw_erased | input | 1 | Send all-ones password |
| pw_index | output | 4 | Index of password word being sent |
| pw_word | input | 16 | Password word for `pw_index` |
| pw_active | output | 1 | Password stream in progress |
| tx_valid | input | 1 | User byte offered |
| tx_data | input | 8 | User byte |
| tx_ready | output | 1 | User byte accepted this clock when valid |
| rx_valid | output | 1 | One-clock strobe: byte received |
| rx_data | output | 8 | Received byte |
| rx_err | output | 1 | Sticky parity/stop error |

## Verification
The hardest case to reach is the timeout boundary. The wait counter starts on the internal clock where the transmitter accepts the sync byte, and no port shows that clock. The bench recovers it from the first low sample of `txd`, which follows that acceptance by exactly one clock. It then checks that `busy` is still high one clock before the limit and low at the limit. A start pulse issued during this wait also shows that a request while busy leaves the pins untouched.

// File: rtl/bsl_link_pkg.sv
package bsl_link_pkg;

    localparam int OVS        = 16;  // receiver ticks per bit
    localparam int FRAME_BITS = 11;  // start + 8 data + parity + stop

    typedef enum logic [2:0] {
        ENT_IDLE,
        ENT_RLO_CLO,   // reset low, clock low
        ENT_RLO_CHI1,  // first clock high
        ENT_RLO_CLO2,  // clock back low
        ENT_RLO_CHI2,  // second clock high
        ENT_RHI_CHI,   // reset released during clock high
        ENT_SYNC,      // offering the sync byte
        ENT_WAIT       // waiting for the reply
    } ent_state_t;

    typedef struct packed {
        logic rst_n;
        logic tclk;
    } pin_lvl_t;

    typedef struct packed {
        logic       valid;
        logic [7:0] data;
    } byte_req_t;

    function automatic logic even_par(input logic [7:0] d);
        return ^d;
    endfunction

    function automatic logic [FRAME_BITS-1:0] tx_frame(input logic [7:0] d);
        return {1'b1, even_par(d), d, 1'b0};
    endfunction

    function automatic pin_lvl_t pins_of(input ent_state_t s);
        pin_lvl_t p;
        case (s)
            ENT_RLO_CLO:  p = '{rst_n: 1'b0, tclk: 1'b0};
            ENT_RLO_CHI1: p = '{rst_n: 1'b0, tclk: 1'b1};
            ENT_RLO_CLO2: p = '{rst_n: 1'b0, tclk: 1'b0};
            ENT_RLO_CHI2: p = '{rst_n: 1'b0, tclk: 1'b1};
            ENT_RHI_CHI:  p = '{rst_n: 1'b1, tclk: 1'b1};
            default:      p = '{rst_n: 1'b1, tclk: 1'b0};
        endcase
        return p;
    endfunction

endpackage

// File: rtl/bsl_tick_gen.sv
module bsl_tick_gen #(
    parameter int TICK_DIV = 814
) (
    input  logic clk,
    input  logic rst,
    output logic tick
);
    localparam int CW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt  <= '0;
            tick <= 1'b0;
        end else if (cnt == CW'(TICK_DIV - 1)) begin
            cnt  <= '0;
            tick <= 1'b1;
        end else begin
            cnt  <= cnt + 1'b1;
            tick <= 1'b0;
        end
    end
endmodule

// File: rtl/bsl_uart_tx.sv
module bsl_uart_tx
    import bsl_link_pkg::*;
#(
    parameter int BIT_CLKS = 16 * 814
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       in_valid,
    input  logic [7:0] in_data,
    output logic       in_ready,
    output logic       txd
);
    localparam int CW = $clog2(BIT_CLKS + 1);

    logic [FRAME_BITS-1:0] sh;
    logic [3:0]            bitn;
    logic [CW-1:0]         cc;
    logic                  active;

    always_ff @(posedge clk) begin
        if (rst) begin
            active <= 1'b0;
            sh     <= '1;
            bitn   <= '0;
            cc     <= '0;
        end else if (!active) begin
            if (in_valid) begin
                sh     <= tx_frame(in_data);
                active <= 1'b1;
                bitn   <= '0;
                cc     <= '0;
            end
        end else if (cc == CW'(BIT_CLKS - 1)) begin
            cc <= '0;
            if (bitn == 4'(FRAME_BITS - 1)) begin
                active <= 1'b0;
            end else begin
                sh   <= {1'b1, sh[FRAME_BITS-1:1]};
                bitn <= bitn + 1'b1;
            end
        end else begin
            cc <= cc + 1'b1;
        end
    end

    assign in_ready = !active;
    assign txd      = active ? sh[0] : 1'b1;

    assert_accept_R8: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready) |=> !in_ready);
    assert_start_low_R8: assert property (@(posedge clk) disable iff (rst)
        (active && bitn == 4'd0) |-> !txd);
    assert_stop_high_R8: assert property (@(posedge clk) disable iff (rst)
        (active && bitn == 4'(FRAME_BITS - 1)) |-> txd);
endmodule

// File: rtl/bsl_uart_rx.sv
module bsl_uart_rx
    import bsl_link_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       tick,
    input  logic       rxd,
    output logic       out_valid,
    output logic [7:0] out_data,
    output logic       err
);
    logic       s1, s2;
    logic       busy;
    logic [3:0] tc;
    logic [3:0] bn;
    logic [7:0] sh;
    logic       par;
    logic       bad;

    always_ff @(posedge clk) begin
        if (rst) begin
            s1 <= 1'b1;
            s2 <= 1'b1;
        end else begin
            s1 <= rxd;
            s2 <= s1;
        end
    end

    assign bad = (par != even_par(sh)) || !s2;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy      <= 1'b0;
            tc        <= '0;
            bn        <= '0;
            sh        <= '0;
            par       <= 1'b0;
            out_valid <= 1'b0;
            out_data  <= '0;
            err       <= 1'b0;
        end else begin
            out_valid <= 1'b0;
            if (!busy) begin
                if (tick && !s2) begin
                    busy <= 1'b1;
                    tc   <= '0;
                    bn   <= '0;
                end
            end else if (tick) begin
                tc <= tc + 1'b1;
                if (tc == 4'(OVS / 2 - 1)) begin
                    bn <= bn + 1'b1;
                    if (bn == 4'd0) begin
                        if (s2) busy <= 1'b0;  // glitch, not a start bit
                    end else if (bn <= 4'd8) begin
                        sh <= {s2, sh[7:1]};
                    end else if (bn == 4'd9) begin
                        par <= s2;
                    end else begin
                        busy      <= 1'b0;
                        out_valid <= 1'b1;
                        out_data  <= sh;
                        if (bad) err <= 1'b1;
                    end
                end
            end
        end
    end

    assert_err_sticky_R10: assert property (@(posedge clk) disable iff (rst)
        err |=> err);
    assert_err_cause_R10: assert property (@(posedge clk) disable iff (rst)
        $rose(err) |-> out_valid);
    assert_valid_pulse_R9: assert property (@(posedge clk) disable iff (rst)
        out_valid |=> !out_valid);
endmodule

// File: rtl/bsl_entry_seq.sv
module bsl_entry_seq
    import bsl_link_pkg::*;
#(
    parameter int         BIT_CLKS     = 16 * 814,
    parameter int         TIMEOUT_CLKS = 1250000,
    parameter logic [7:0] SYNC_BYTE    = 8'h80,
    parameter int         PHW          = 16
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           start,
    input  logic [PHW-1:0] phase_len,
    input  logic           tx_ready,
    input  logic           rx_valid,
    input  logic [7:0]     rx_data,
    output logic           tgt_rst_n,
    output logic           tgt_tclk,
    output byte_req_t      tx_req,
    output logic           busy,
    output logic           ack_valid,
    output logic [7:0]     ack_data,
    output logic           timeout
);
    localparam int TW = $clog2(TIMEOUT_CLKS + 1);

    ent_state_t     state;
    logic [PHW-1:0] cnt;
    logic [PHW-1:0] hold;
    logic [TW-1:0]  tcnt;
    pin_lvl_t       lvl;

    assign hold = (phase_len < PHW'(BIT_CLKS)) ? PHW'(BIT_CLKS) : phase_len;

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ENT_IDLE;
            cnt       <= '0;
            tcnt      <= '0;
            ack_valid <= 1'b0;
            ack_data  <= '0;
            timeout   <= 1'b0;
        end else begin
            ack_valid <= 1'b0;
            case (state)
                ENT_IDLE: begin
                    if (start) begin
                        state   <= ENT_RLO_CLO;
                        cnt     <= hold - 1'b1;
                        timeout <= 1'b0;
                    end
                end
                ENT_RLO_CLO, ENT_RLO_CHI1, ENT_RLO_CLO2, ENT_RLO_CHI2, ENT_RHI_CHI: begin
                    if (cnt == '0) begin
                        state <= ent_state_t'(state + 3'd1);
                        cnt   <= hold - 1'b1;
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                ENT_SYNC: begin
                    if (tx_ready) begin
                        state <= ENT_WAIT;
                        tcnt  <= '0;
                    end
                end
                default: begin
                    if (rx_valid) begin
                        ack_valid <= 1'b1;
                        ack_data  <= rx_data;
                        state     <= ENT_IDLE;
                    end else if (tcnt == TW'(TIMEOUT_CLKS - 1)) begin
                        timeout <= 1'b1;
                        state   <= ENT_IDLE;
                    end else begin
                        tcnt <= tcnt + 1'b1;
                    end
                end
            endcase
        end
    end

    assign lvl         = pins_of(state);
    assign tgt_rst_n   = lvl.rst_n;
    assign tgt_tclk    = lvl.tclk;
    assign busy        = (state != ENT_IDLE);
    assign tx_req      = '{valid: (state == ENT_SYNC), data: SYNC_BYTE};

    assert_rst_rise_in_high_R2: assert property (@(posedge clk) disable iff (rst)
        $rose(tgt_rst_n) |-> tgt_tclk);
    assert_clock_fall_ends_R2: assert property (@(posedge clk) disable iff (rst)
        ($fell(tgt_tclk) && tgt_rst_n) |-> (state == ENT_SYNC));
    assert_busy_on_start_R5: assert property (@(posedge clk) disable iff (rst)
        (start && !busy) |=> busy);
    assert_ack_ends_R6: assert property (@(posedge clk) disable iff (rst)
        ack_valid |-> !busy);
    assert_timeout_idle_R7: assert property (@(posedge clk) disable iff (rst)
        timeout |-> !busy);
endmodule

// File: rtl/bsl_pw_stream.sv
module bsl_pw_stream
    import bsl_link_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        go,
    input  logic        erased,
    input  logic [15:0] word,
    input  logic        tx_ready,
    output logic [3:0]  index,
    output byte_req_t   tx_req,
    output logic        active
);
    localparam int NBYTES = 32;
    localparam int BW     = $clog2(NBYTES);

    logic [BW-1:0] bc;
    logic [15:0]   w;

    always_ff @(posedge clk) begin
        if (rst) begin
            active <= 1'b0;
            bc     <= '0;
        end else if (!active) begin
            if (go) begin
                active <= 1'b1;
                bc     <= '0;
            end
        end else if (tx_ready) begin
            if (bc == BW'(NBYTES - 1)) active <= 1'b0;
            else                       bc     <= bc + 1'b1;
        end
    end

    assign index  = bc[BW-1:1];
    assign w      = erased ? 16'hFFFF : word;
    assign tx_req = '{valid: active, data: bc[0] ? w[15:8] : w[7:0]};

    assert_index_ascends_R11: assert property (@(posedge clk) disable iff (rst)
        (active && $past(active)) |-> (index >= $past(index)));
    assert_erased_bytes_R12: assert property (@(posedge clk) disable iff (rst)
        (active && erased) |-> (tx_req.data == 8'hFF));
endmodule

// File: rtl/bsl_entry_link.sv
module bsl_entry_link
    import bsl_link_pkg::*;
#(
    parameter int         TICK_DIV     = 814,
    parameter int         TIMEOUT_CLKS = 1250000,
    parameter logic [7:0] SYNC_BYTE    = 8'h80,
    parameter int         PHW          = 16
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           entry_start,
    input  logic [PHW-1:0] phase_len,
    output logic           tgt_reset_n,
    output logic           tgt_testclk,
    output logic           txd,
    input  logic           rxd,
    output logic           busy,
    output logic           ack_valid,
    output logic [7:0]     ack_data,
    output logic           entry_timeout,
    input  logic           pw_go,
    input  logic           pw_erased,
    output logic [3:0]     pw_index,
    input  logic [15:0]    pw_word,
    output logic           pw_active,
    input  logic           tx_valid,
    input  logic [7:0]     tx_data,
    output logic           tx_ready,
    output logic           rx_valid,
    output logic [7:0]     rx_data,
    output logic           rx_err
);
    localparam int BIT_CLKS = OVS * TICK_DIV;

    logic      tick;
    logic      utx_ready;
    byte_req_t ent_req, pw_req, usr_req, sel_req;

    assign usr_req = '{valid: tx_valid, data: tx_data};

    always_comb begin
        if (busy)           sel_req = ent_req;
        else if (pw_active) sel_req = pw_req;
        else                sel_req = usr_req;
    end

    bsl_tick_gen #(.TICK_DIV(TICK_DIV)) u_tick (
        .clk(clk), .rst(rst), .tick(tick)
    );

    bsl_uart_tx #(.BIT_CLKS(BIT_CLKS)) u_tx (
        .clk(clk), .rst(rst),
        .in_valid(sel_req.valid), .in_data(sel_req.data),
        .in_ready(utx_ready), .txd(txd)
    );

    bsl_uart_rx u_rx (
        .clk(clk), .rst(rst), .tick(tick), .rxd(rxd),
        .out_valid(rx_valid), .out_data(rx_data), .err(rx_err)
    );

    bsl_entry_seq #(
        .BIT_CLKS(BIT_CLKS), .TIMEOUT_CLKS(TIMEOUT_CLKS),
        .SYNC_BYTE(SYNC_BYTE), .PHW(PHW)
    ) u_entry (
        .clk(clk), .rst(rst),
        .start(entry_start && !pw_active),
        .phase_len(phase_len),
        .tx_ready(busy && utx_ready),
        .rx_valid(rx_valid), .rx_data(rx_data),
        .tgt_rst_n(tgt_reset_n), .tgt_tclk(tgt_testclk),
        .tx_req(ent_req), .busy(busy),
        .ack_valid(ack_valid), .ack_data(ack_data),
        .timeout(entry_timeout)
    );

    bsl_pw_stream u_pw (
        .clk(clk), .rst(rst),
        .go(pw_go && !busy && !entry_start),
        .erased(pw_erased), .word(pw_word),
        .tx_ready(!busy && pw_active && utx_ready),
        .index(pw_index), .tx_req(pw_req), .active(pw_active)
    );

    assign tx_ready = !busy && !pw_active && utx_ready;

    assert_user_blocked_R13: assert property (@(posedge clk) disable iff (rst)
        (busy || pw_active) |-> !tx_ready);
    assert_one_owner_R13: assert property (@(posedge clk) disable iff (rst)
        !(busy && pw_active));
endmodule

// File: tb/bsl_entry_link_test.sv
module bsl_entry_link_test;
    localparam int TICK_DIV = 2;
    localparam int BIT      = 16 * TICK_DIV;
    localparam int TMO      = 3000;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic entry_start = 1'b0;
    logic [15:0] phase_len = 16'd40;
    logic tgt_reset_n, tgt_testclk, txd;
    logic rxd = 1'b1;
    logic busy, ack_valid, entry_timeout, pw_active, tx_ready, rx_valid, rx_err;
    logic [7:0] ack_data, rx_data;
    logic pw_go = 1'b0, pw_erased = 1'b0;
    logic [3:0] pw_index;
    logic [15:0] pw_word;
    logic tx_valid = 1'b0;
    logic [7:0] tx_data = 8'h00;

    int total = 0, bad = 0, cyc = 0, fall_cyc = 0;
    int ack_cnt = 0, rx_cnt = 0;
    logic [7:0] ack_last = 8'h00, rx_last = 8'h00;

    always #4 clk = ~clk;

    function automatic logic [15:0] pw_of(input int i);
        return 16'h1234 ^ (16'(i) * 16'h0F11);
    endfunction
    assign pw_word = pw_of(int'(pw_index));

    bsl_entry_link #(.TICK_DIV(TICK_DIV), .TIMEOUT_CLKS(TMO)) uut (
        .clk(clk), .rst(rst), .entry_start(entry_start), .phase_len(phase_len),
        .tgt_reset_n(tgt_reset_n), .tgt_testclk(tgt_testclk), .txd(txd), .rxd(rxd),
        .busy(busy), .ack_valid(ack_valid), .ack_data(ack_data),
        .entry_timeout(entry_timeout), .pw_go(pw_go), .pw_erased(pw_erased),
        .pw_index(pw_index), .pw_word(pw_word), .pw_active(pw_active),
        .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(tx_ready),
        .rx_valid(rx_valid), .rx_data(rx_data), .rx_err(rx_err)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (ack_valid) begin ack_cnt <= ack_cnt + 1; ack_last <= ack_data; end
        if (rx_valid)  begin rx_cnt  <= rx_cnt + 1;  rx_last  <= rx_data;  end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic uart_get(output logic [7:0] b, output logic pok, output logic sok);
        int g = 0;
        logic p;
        while (txd !== 1'b0 && g < 8000) begin @(negedge clk); g++; end
        chk("R8 frame start seen", 32'(g < 8000), 32'd1);
        fall_cyc = cyc;
        repeat (BIT / 2) @(negedge clk);
        chk("R8 start bit low", 32'(txd), 32'd0);
        for (int i = 0; i < 8; i++) begin
            repeat (BIT) @(negedge clk);
            b[i] = txd;
        end
        repeat (BIT) @(negedge clk);
        p = txd;
        repeat (BIT) @(negedge clk);
        sok = txd;
        pok = (p == ^b);
    endtask

    task automatic uart_send(input logic [7:0] b, input logic bp, input logic bs);
        logic [10:0] f;
        f = {~bs, (^b) ^ bp, b, 1'b0};
        for (int i = 0; i < 11; i++) begin
            rxd = f[i];
            repeat (BIT) @(negedge clk);
        end
        rxd = 1'b1;
    endtask

    // Fires the entry waveform and checks ordering (R2) and phase length (R3).
    task automatic run_entry(input logic [15:0] pl);
        int t[6];
        logic [1:0] lv[6];
        logic [1:0] prev, cur;
        int n = 0, hold;
        hold = (int'(pl) < BIT) ? BIT : int'(pl);
        phase_len = pl;
        @(negedge clk); entry_start = 1'b1;
        @(negedge clk); entry_start = 1'b0;
        chk("R5 busy after start", 32'(busy), 32'd1);
        chk("R13 tx_ready low in entry", 32'(tx_ready), 32'd0);
        prev = 2'b10;
        for (int g = 0; g < 2000 && n < 6; g++) begin
            cur = {tgt_reset_n, tgt_testclk};
            if (cur != prev) begin t[n] = cyc; lv[n] = cur; prev = cur; n++; end
            if (n < 6) @(negedge clk);
        end
        chk("R2 six pin steps", 32'(n), 32'd6);
        chk("R2 step0 00", 32'(lv[0]), 32'b00);
        chk("R2 step1 01", 32'(lv[1]), 32'b01);
        chk("R2 step2 00", 32'(lv[2]), 32'b00);
        chk("R2 step3 01", 32'(lv[3]), 32'b01);
        chk("R2 step4 11", 32'(lv[4]), 32'b11);
        chk("R2 step5 10", 32'(lv[5]), 32'b10);
        for (int k = 0; k < 5; k++)
            chk("R3 phase length", 32'(t[k+1] - t[k]), 32'(hold));
    endtask

    localparam logic [9:0] VEC [6] = '{
        {8'h55, 1'b0, 1'b0},
        {8'h00, 1'b0, 1'b0},
        {8'hFF, 1'b0, 1'b0},
        {8'hA3, 1'b0, 1'b0},
        {8'h3C, 1'b1, 1'b0},
        {8'h81, 1'b0, 1'b1}
    };

    initial begin
        repeat (200000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [7:0] b;
        logic pok, sok, exp_err;
        int a0, r0;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 reset_n", 32'(tgt_reset_n), 32'd1);
        chk("R1 testclk", 32'(tgt_testclk), 32'd0);
        chk("R1 txd idle", 32'(txd), 32'd1);
        chk("R1 busy", 32'(busy), 32'd0);
        chk("R1 timeout", 32'(entry_timeout), 32'd0);
        chk("R1 pw_active", 32'(pw_active), 32'd0);
        chk("R1 rx_err", 32'(rx_err), 32'd0);

        // Entry with reply
        run_entry(16'd40);
        uart_get(b, pok, sok);
        chk("R4 sync byte", 32'(b), 32'h80);
        chk("R8 sync parity", 32'(pok), 32'd1);
        chk("R8 sync stop", 32'(sok), 32'd1);
        chk("R5 busy while waiting", 32'(busy), 32'd1);
        a0 = ack_cnt;
        uart_send(8'h90, 1'b0, 1'b0);
        @(negedge clk);
        chk("R6 one ack strobe", 32'(ack_cnt - a0), 32'd1);
        chk("R6 ack value", 32'(ack_last), 32'h90);
        chk("R5 busy cleared by ack", 32'(busy), 32'd0);
        chk("R7 no timeout", 32'(entry_timeout), 32'd0);

        // Entry with short phase request and no reply
        repeat (BIT) @(negedge clk);
        run_entry(16'd5);
        uart_get(b, pok, sok);
        chk("R4 sync byte again", 32'(b), 32'h80);
        @(negedge clk); entry_start = 1'b1;
        @(negedge clk); entry_start = 1'b0;
        repeat (3) @(negedge clk);
        chk("R5 ignored start reset_n", 32'(tgt_reset_n), 32'd1);
        chk("R5 ignored start testclk", 32'(tgt_testclk), 32'd0);
        while (cyc < fall_cyc + TMO - 1) @(negedge clk);
        chk("R7 busy before limit", 32'(busy), 32'd1);
        @(negedge clk);
        chk("R7 busy at limit", 32'(busy), 32'd0);
        chk("R7 timeout flag", 32'(entry_timeout), 32'd1);

        // Password from words
        chk("R10 no error yet", 32'(rx_err), 32'd0);
        @(negedge clk); pw_go = 1'b1;
        @(negedge clk); pw_go = 1'b0;
        chk("R11 pw_active", 32'(pw_active), 32'd1);
        chk("R11 first index", 32'(pw_index), 32'd0);
        chk("R13 tx_ready low in password", 32'(tx_ready), 32'd0);
        for (int k = 0; k < 32; k++) begin
            logic [15:0] w;
            w = pw_of(k / 2);
            uart_get(b, pok, sok);
            chk("R11 password byte", 32'(b), 32'((k % 2) ? w[15:8] : w[7:0]));
        end
        repeat (BIT) @(negedge clk);
        chk("R11 stream ended", 32'(pw_active), 32'd0);

        // Erased password
        pw_erased = 1'b1;
        @(negedge clk); pw_go = 1'b1;
        @(negedge clk); pw_go = 1'b0;
        for (int k = 0; k < 32; k++) begin
            uart_get(b, pok, sok);
            chk("R12 erased byte", 32'(b), 32'hFF);
        end
        repeat (BIT) @(negedge clk);
        pw_erased = 1'b0;

        // Vector table: user transmit then receive
        exp_err = 1'b0;
        for (int v = 0; v < 6; v++) begin
            logic [7:0] d;
            d = VEC[v][9:2];
            while (!tx_ready) @(negedge clk);
            tx_valid = 1'b1; tx_data = d;
            @(negedge clk);
            tx_valid = 1'b0;
            uart_get(b, pok, sok);
            chk("R8 user byte", 32'(b), 32'(d));
            chk("R8 user parity", 32'(pok), 32'd1);
            chk("R8 user stop", 32'(sok), 32'd1);
            r0 = rx_cnt;
            uart_send(d, VEC[v][1], VEC[v][0]);
            exp_err = exp_err | VEC[v][1] | VEC[v][0];
            chk("R9 one rx strobe", 32'(rx_cnt - r0), 32'd1);
            chk("R9 rx data", 32'(rx_last), 32'(d));
            chk("R10 rx_err", 32'(rx_err), 32'(exp_err));
        end
        repeat (16 * BIT) @(negedge clk);
        chk("R10 error still set", 32'(rx_err), 32'd1);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule